// File: doc/BRIEF.md
# Shared Two-Class Rename Register Pool

This block renames two unrelated architectural register classes into one physical register file. One class holds eight 64-bit vector-mask registers. The other holds eight legacy floating-point registers, and the MMX names alias onto these same eight. Both classes take their physical tags from one free pool of 128 speculative entries, with no per-class partition. Heavy use of one class therefore leaves less room for the other.

For each rename request the block grants the lowest-numbered free physical tag and returns the tag that the destination register held before. It points the speculative map at the new tag. When the pool is empty it raises a stall, whatever the mix of classes in the requests. A retiring instruction hands back its previous tag and records its new tag in the committed map. A flush copies the committed map over the speculative one and rebuilds the pool in one cycle.

The block also holds a 144-entry by 96-bit data array with one write port and one read port. For a floating-point entry the 96 bits are an 80-bit extended value and a 16-bit status word. A mask entry uses the low 64 bits. The 16 architectural registers own tags 0 to 15 at reset, and the 128 poolable tags are 16 to 143.

Top module: `shared_rename_pool`

## Requirements
- R1: After reset, mask register i maps to tag i, floating-point register i maps to tag 8+i (i = 0..7), and alloc_stall is low.
- R2: When a request is not stalled, alloc_tag in that cycle is the lowest-numbered free tag. alloc_prev is the current speculative mapping of the register named by {alloc_cls, alloc_idx}, where class 0 is mask and class 1 is floating-point/MMX. From the next cycle the map lookup returns the new tag.
- R3: With no commits, 128 granted requests empty the pool and the 129th request sees alloc_stall high. This holds for only mask requests, only floating-point requests, and requests alternating between the two classes. A stalled request changes neither the map nor the pool.
- R4: A commit returns commit_prev_tag to the pool in its cycle. From the next cycle that tag can be granted and a stall caused by an empty pool clears.
- R5: A flush raises alloc_stall and ignores any request in that cycle. From the next cycle every lookup returns the committed mapping, and exactly 128 further grants are possible before a stall.
- R6: A commit writes commit_new_tag into the committed map entry named by {commit_cls, commit_idx}. A later flush makes that tag visible through the lookup port.
- R7: A write with wr_mask high stores wr_data[63:0] in bits 63:0 of the entry and zeroes bits 95:64. The stored value reads back from the next cycle.
- R8: A write with wr_mask low stores all 96 bits of wr_data (bits 79:0 value, bits 95:80 status). The stored value reads back from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Rename request |
| alloc_cls | input | 1 | Request class: 0 mask, 1 floating-point/MMX |
| alloc_idx | input | 3 | Architectural register index |
| alloc_stall | output | 1 | Pool empty or flush in progress; request not granted |
| alloc_tag | output | 8 | Granted physical tag |
| alloc_prev | output | 8 | Previous speculative tag of the destination |
| commit_valid | input | 1 | Retirement of one renamed instruction |
| commit_cls | input | 1 | Class of the retiring destination |
| commit_idx | input | 3 | Index of the retiring destination |
| commit_new_tag | input | 8 | Tag the destination now holds in the committed map |
| commit_prev_tag | input | 8 | Tag returned to the pool |
| flush | input | 1 | Restore the speculative map from the committed map |
| lk_cls | input | 1 | Lookup class |
| lk_idx | input | 3 | Lookup index |
| lk_tag | output | 8 | Speculative mapping of the looked-up register |
| wr_en | input | 1 | Data array write enable |
| wr_mask | input | 1 | Write is a mask value (low 64 bits, upper zeroed) |
| wr_tag | input | 8 | Data array write address |
| wr_data | input | 96 | Data array write value |
| rd_tag | input | 8 | Data array read address |
| rd_data | output | 96 | Data array read value |

## Verification
The grant outputs alloc_stall, alloc_tag and alloc_prev, together with lk_tag and rd_data, are combinational in the cycle a request or address is presented. Map, pool and array updates become visible one cycle after the clock edge that takes them. The bench drives inputs on the falling edge and compares every output a moment later, before the rising edge. It then moves its reference model forward on that rising edge, so that the update it applies is the one the design applies. Exhaustion is checked at exactly the 129th request in each of the three class mixes.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int ARCH_PER_CLASS = 8;
    localparam int NUM_CLASSES    = 2;
    localparam int SPEC_ENTRIES   = 128;
    localparam int ARCH_TOTAL     = ARCH_PER_CLASS * NUM_CLASSES;
    localparam int PHYS_ENTRIES   = SPEC_ENTRIES + ARCH_TOTAL;
    localparam int TAG_W          = $clog2(PHYS_ENTRIES);
    localparam int IDX_W          = $clog2(ARCH_PER_CLASS);
    localparam int SLOT_W         = $clog2(ARCH_TOTAL);
    localparam int CNT_W          = $clog2(PHYS_ENTRIES + 1);
    localparam int FPV_W          = 80;
    localparam int STAT_W         = 16;
    localparam int ENTRY_W        = FPV_W + STAT_W;
    localparam int MASK_W         = 64;

    typedef logic [TAG_W-1:0]   ptag_t;
    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic {
        CLS_MASK = 1'b0,
        CLS_FPX  = 1'b1
    } reg_class_e;

    typedef struct packed {
        reg_class_e       cls;
        logic [IDX_W-1:0] idx;
    } arch_reg_t;

    typedef struct packed {
        logic      valid;
        arch_reg_t dst;
        ptag_t     new_tag;
        ptag_t     prev_tag;
    } retire_t;

    function automatic logic [SLOT_W-1:0] slot_of(arch_reg_t r);
        return {r.cls, r.idx};
    endfunction

    function automatic entry_t shape_entry(logic is_mask, entry_t d);
        entry_t e;
        e = d;
        if (is_mask) e = {{(ENTRY_W-MASK_W){1'b0}}, d[MASK_W-1:0]};
        return e;
    endfunction
endpackage

// File: rtl/srp_free_pool.sv
module srp_free_pool
    import srp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic                    give,
    input  ptag_t                   give_tag,
    input  logic                    rebuild,
    input  logic [PHYS_ENTRIES-1:0] owned,
    output ptag_t                   grant_tag,
    output logic                    empty
);
    logic [PHYS_ENTRIES-1:0] avail;
    logic [CNT_W-1:0]        count;

    always_comb begin
        grant_tag = '0;
        for (int i = PHYS_ENTRIES - 1; i >= 0; i--) begin
            if (avail[i]) grant_tag = TAG_W'(i);
        end
    end

    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_ENTRIES; i++) avail[i] <= (i >= ARCH_TOTAL);
            count <= CNT_W'(SPEC_ENTRIES);
        end else if (rebuild) begin
            avail <= ~owned;
            count <= CNT_W'(SPEC_ENTRIES);
        end else begin
            if (take) avail[grant_tag] <= 1'b0;
            if (give) avail[give_tag]  <= 1'b1;
            count <= count - CNT_W'(take) + CNT_W'(give);
        end
    end

    // R3
    grant_is_free_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> avail[grant_tag]);

    // R3
    count_tracks_bits_chk: assert property (@(posedge clk) disable iff (rst)
        count == CNT_W'($countones(avail)));

    // R4
    give_frees_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (give && !rebuild) |=> avail[$past(give_tag)]);

    // R5
    rebuild_refills_chk: assert property (@(posedge clk) disable iff (rst)
        rebuild |=> (count == CNT_W'(SPEC_ENTRIES)));
endmodule

// File: rtl/srp_rename_map.sv
module srp_rename_map
    import srp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spec_we,
    input  arch_reg_t               spec_dst,
    input  ptag_t                   spec_tag,
    input  retire_t                 retire,
    input  logic                    flush,
    input  arch_reg_t               rd_a,
    output ptag_t                   rd_a_tag,
    input  arch_reg_t               rd_b,
    output ptag_t                   rd_b_tag,
    output logic [PHYS_ENTRIES-1:0] owned_nxt
);
    ptag_t [ARCH_TOTAL-1:0] spec_map;
    ptag_t [ARCH_TOTAL-1:0] comm_map;
    ptag_t [ARCH_TOTAL-1:0] comm_nxt;

    assign rd_a_tag = spec_map[slot_of(rd_a)];
    assign rd_b_tag = spec_map[slot_of(rd_b)];

    always_comb begin
        comm_nxt = comm_map;
        if (retire.valid) comm_nxt[slot_of(retire.dst)] = retire.new_tag;
    end

    always_comb begin
        owned_nxt = '0;
        for (int j = 0; j < ARCH_TOTAL; j++) owned_nxt[comm_nxt[j]] = 1'b1;
    end

    generate
        for (genvar g = 0; g < ARCH_TOTAL; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    spec_map[g] <= TAG_W'(g);
                    comm_map[g] <= TAG_W'(g);
                end else begin
                    comm_map[g] <= comm_nxt[g];
                    if (flush)
                        spec_map[g] <= comm_nxt[g];
                    else if (spec_we && slot_of(spec_dst) == SLOT_W'(g))
                        spec_map[g] <= spec_tag;
                end
            end
        end
    endgenerate

    // R5
    flush_restores_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (spec_map == comm_map));

    // R6
    retire_records_chk: assert property (@(posedge clk) disable iff (rst)
        retire.valid |=> (comm_map[$past(slot_of(retire.dst))] == $past(retire.new_tag)));

    // R2
    spec_write_chk: assert property (@(posedge clk) disable iff (rst)
        (spec_we && !flush) |=> (spec_map[$past(slot_of(spec_dst))] == $past(spec_tag)));
endmodule

// File: rtl/srp_data_array.sv
module srp_data_array
    import srp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  logic   we_mask,
    input  ptag_t  waddr,
    input  entry_t wdata,
    input  ptag_t  raddr,
    output entry_t rdata
);
    entry_t mem [PHYS_ENTRIES];

    assign rdata = (int'(raddr) < PHYS_ENTRIES) ? mem[raddr] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_ENTRIES; i++) mem[i] <= '0;
        end else if (we && int'(waddr) < PHYS_ENTRIES) begin
            mem[waddr] <= shape_entry(we_mask, wdata);
        end
    end

    // R7
    mask_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && we_mask && int'(waddr) < PHYS_ENTRIES) |=>
            (mem[$past(waddr)][ENTRY_W-1:MASK_W] == '0));

    // R8
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !we_mask && int'(waddr) < PHYS_ENTRIES) |=>
            (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/shared_rename_pool.sv
module shared_rename_pool
    import srp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_req,
    input  logic                     alloc_cls,
    input  logic [IDX_W-1:0]         alloc_idx,
    output logic                     alloc_stall,
    output logic [TAG_W-1:0]         alloc_tag,
    output logic [TAG_W-1:0]         alloc_prev,
    input  logic                     commit_valid,
    input  logic                     commit_cls,
    input  logic [IDX_W-1:0]         commit_idx,
    input  logic [TAG_W-1:0]         commit_new_tag,
    input  logic [TAG_W-1:0]         commit_prev_tag,
    input  logic                     flush,
    input  logic                     lk_cls,
    input  logic [IDX_W-1:0]         lk_idx,
    output logic [TAG_W-1:0]         lk_tag,
    input  logic                     wr_en,
    input  logic                     wr_mask,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [ENTRY_W-1:0]       wr_data,
    input  logic [TAG_W-1:0]         rd_tag,
    output logic [ENTRY_W-1:0]       rd_data
);
    arch_reg_t               req_dst;
    arch_reg_t               lk_reg;
    retire_t                 ret;
    logic                    pool_empty;
    logic                    fire;
    ptag_t                   grant;
    logic [PHYS_ENTRIES-1:0] owned_nxt;

    assign req_dst = '{cls: reg_class_e'(alloc_cls), idx: alloc_idx};
    assign lk_reg  = '{cls: reg_class_e'(lk_cls),    idx: lk_idx};
    assign ret     = '{valid:    commit_valid,
                       dst:      '{cls: reg_class_e'(commit_cls), idx: commit_idx},
                       new_tag:  commit_new_tag,
                       prev_tag: commit_prev_tag};

    assign alloc_stall = pool_empty || flush;
    assign fire        = alloc_req && !alloc_stall;
    assign alloc_tag   = grant;

    srp_free_pool u_pool (
        .clk       (clk),
        .rst       (rst),
        .take      (fire),
        .give      (ret.valid),
        .give_tag  (ret.prev_tag),
        .rebuild   (flush),
        .owned     (owned_nxt),
        .grant_tag (grant),
        .empty     (pool_empty)
    );

    srp_rename_map u_map (
        .clk       (clk),
        .rst       (rst),
        .spec_we   (fire),
        .spec_dst  (req_dst),
        .spec_tag  (grant),
        .retire    (ret),
        .flush     (flush),
        .rd_a      (req_dst),
        .rd_a_tag  (alloc_prev),
        .rd_b      (lk_reg),
        .rd_b_tag  (lk_tag),
        .owned_nxt (owned_nxt)
    );

    srp_data_array u_data (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .we_mask (wr_mask),
        .waddr   (wr_tag),
        .wdata   (wr_data),
        .raddr   (rd_tag),
        .rdata   (rd_data)
    );

    // R5
    flush_blocks_grant_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> alloc_stall);

    // R2
    grant_outside_arch_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (alloc_tag == TAG_W'(ARCH_TOTAL)));
endmodule

// File: tb/shared_rename_pool_test.sv
module shared_rename_pool_test;
    localparam int NPHYS = 144;
    localparam int NSPEC = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_req, alloc_cls;
    logic [2:0]  alloc_idx;
    logic        alloc_stall;
    logic [7:0]  alloc_tag, alloc_prev;
    logic        commit_valid, commit_cls;
    logic [2:0]  commit_idx;
    logic [7:0]  commit_new_tag, commit_prev_tag;
    logic        flush;
    logic        lk_cls;
    logic [2:0]  lk_idx;
    logic [7:0]  lk_tag;
    logic        wr_en, wr_mask;
    logic [7:0]  wr_tag;
    logic [95:0] wr_data;
    logic [7:0]  rd_tag;
    logic [95:0] rd_data;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    // reference model
    int          spec_m [16];
    int          com_m  [16];
    bit          free_m [NPHYS];
    logic [95:0] mem_m  [NPHYS];

    always #5 clk = ~clk;

    shared_rename_pool uut (.*);

    task automatic check(bit ok, string req, logic [95:0] act, logic [95:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < NPHYS; i++) if (free_m[i]) return i;
        return -1;
    endfunction

    function automatic int free_cnt();
        int n = 0;
        for (int i = 0; i < NPHYS; i++) if (free_m[i]) n++;
        return n;
    endfunction

    task automatic model_reset();
        for (int j = 0; j < 16; j++) begin spec_m[j] = j; com_m[j] = j; end
        for (int i = 0; i < NPHYS; i++) begin free_m[i] = (i >= 16); mem_m[i] = '0; end
    endtask

    task automatic idle_inputs();
        alloc_req = 0; alloc_cls = 0; alloc_idx = 0;
        commit_valid = 0; commit_cls = 0; commit_idx = 0;
        commit_new_tag = 0; commit_prev_tag = 0;
        flush = 0; wr_en = 0; wr_mask = 0; wr_tag = 0; wr_data = '0;
    endtask

    // inputs are set at the falling edge; outputs compared 1 ns later
    task automatic tick();
        bit exp_stall;
        int slot, low;
        lk_cls = cyc[3]; lk_idx = cyc[2:0];
        rd_tag = 8'(cyc % NPHYS);
        #1;
        exp_stall = flush || (free_cnt() == 0);
        low  = low_free();
        slot = {alloc_cls, alloc_idx};
        if (alloc_req) begin
            check(alloc_stall == exp_stall, "R3 stall", 96'(alloc_stall), 96'(exp_stall));
            if (!exp_stall) begin
                check(alloc_tag == 8'(low), "R2 grant tag", 96'(alloc_tag), 96'(low));
                check(alloc_prev == 8'(spec_m[slot]), "R2 previous tag",
                      96'(alloc_prev), 96'(spec_m[slot]));
            end
        end
        check(lk_tag == 8'(spec_m[{lk_cls, lk_idx}]), "R5 map lookup",
              96'(lk_tag), 96'(spec_m[{lk_cls, lk_idx}]));
        check(rd_data == mem_m[rd_tag], "R7 R8 array read", rd_data, mem_m[rd_tag]);
        @(posedge clk);
        if (flush) begin
            if (commit_valid) com_m[{commit_cls, commit_idx}] = int'(commit_new_tag);
            for (int i = 0; i < NPHYS; i++) free_m[i] = 1;
            for (int j = 0; j < 16; j++) begin spec_m[j] = com_m[j]; free_m[com_m[j]] = 0; end
        end else begin
            if (alloc_req && !exp_stall) begin free_m[low] = 0; spec_m[slot] = low; end
            if (commit_valid) begin
                com_m[{commit_cls, commit_idx}] = int'(commit_new_tag);
                free_m[commit_prev_tag] = 1;
            end
        end
        if (wr_en) mem_m[wr_tag] = wr_mask ? {32'h0, wr_data[63:0]} : wr_data;
        cyc++;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_alloc(bit cls, int idx);
        alloc_req = 1; alloc_cls = cls; alloc_idx = 3'(idx);
        tick();
    endtask

    task automatic do_flush();
        flush = 1; alloc_req = 1;   // request in the flush cycle must be ignored (R5)
        tick();
    endtask

    // fill the pool with a class pattern; 0 mask, 1 fp, 2 alternating
    task automatic fill_and_probe(int pat, string name);
        for (int n = 0; n < NSPEC; n++) begin
            bit c = (pat == 2) ? n[0] : pat[0];
            do_alloc(c, n % 8);
        end
        alloc_req = 1; alloc_cls = 0; alloc_idx = 3'd5;
        #1;
        check(alloc_stall == 1'b1, {"R3 129th request stalls ", name}, 96'(alloc_stall), 96'd1);
        tick();
    endtask

    initial begin
        idle_inputs();
        lk_cls = 0; lk_idx = 0; rd_tag = 0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        for (int j = 0; j < 16; j++) begin
            lk_cls = j[3]; lk_idx = j[2:0];
            #1;
            check(lk_tag == 8'(j), "R1 reset mapping", 96'(lk_tag), 96'(j));
        end
        alloc_req = 1; alloc_cls = 1; alloc_idx = 0;
        #1;
        check(alloc_stall == 1'b0, "R1 no stall after reset", 96'(alloc_stall), 96'd0);
        check(alloc_tag == 8'd16, "R2 first grant", 96'(alloc_tag), 96'd16);
        alloc_req = 0;

        for (int k = 0; k < 16; k++) tick();

        fill_and_probe(0, "mask only");
        do_flush();
        for (int k = 0; k < 16; k++) tick();
        fill_and_probe(1, "fp only");
        do_flush();
        fill_and_probe(2, "alternating");

        // R4: commit the first alternating grant, freeing tag 0 (old mask 0)
        commit_valid = 1; commit_cls = 0; commit_idx = 0;
        commit_new_tag = 8'(com_m[0] == 0 ? 16 : 16); commit_prev_tag = 8'd0;
        alloc_req = 1; alloc_cls = 1; alloc_idx = 2;
        tick();
        alloc_req = 1; alloc_cls = 1; alloc_idx = 2;
        #1;
        check(alloc_stall == 1'b0, "R4 stall clears after commit", 96'(alloc_stall), 96'd0);
        check(alloc_tag == 8'd0, "R4 freed tag is granted", 96'(alloc_tag), 96'd0);
        tick();

        // R6: committed map now maps mask 0 to tag 16; flush exposes it
        do_flush();
        lk_cls = 0; lk_idx = 0;
        #1;
        check(lk_tag == 8'd16, "R6 committed tag visible after flush", 96'(lk_tag), 96'd16);
        for (int k = 0; k < 20; k++) tick();

        // R7 / R8 data array
        wr_en = 1; wr_mask = 1; wr_tag = 8'd40; wr_data = {32'hDEADBEEF, 64'h0123_4567_89AB_CDEF};
        tick();
        rd_tag = 8'd40;
        #1;
        check(rd_data == {32'h0, 64'h0123_4567_89AB_CDEF}, "R7 mask write zeroes upper bits",
              rd_data, {32'h0, 64'h0123_4567_89AB_CDEF});
        wr_en = 1; wr_mask = 0; wr_tag = 8'd143; wr_data = {16'hA5C3, 80'h4000_8000_0000_0000_0001};
        tick();
        rd_tag = 8'd143;
        #1;
        check(rd_data == {16'hA5C3, 80'h4000_8000_0000_0000_0001}, "R8 full-width write",
              rd_data, {16'hA5C3, 80'h4000_8000_0000_0000_0001});
        for (int k = 0; k < 150; k++) tick();

        // R5: after the flush exactly 128 grants fit again
        do_flush();
        fill_and_probe(2, "after flush");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule